// File: doc/BRIEF.md
# Depth-Cascade Token Controller

This block is the per-slice control logic that lets several identical FIFO slices share one write bus and one read bus and act as a single deeper buffer. Each slice holds a write pointer, a read pointer and a word count for its own storage. It also holds a write token and a read token. Only the slice that holds the write token accepts writes. Only the slice that holds the read token performs reads and drives the shared output bus. The storage array itself is outside the block. The slice gives a write address and a write strobe to its storage, and a read address and a read strobe from it.

The tokens travel around a ring. Each slice's write expansion-out goes to the next slice's write expansion-in, and the same holds for the read signals. The last slice wraps back to the first. When a slice fills its last location, it hands the write token on. When it drains its last location, it hands the read token on. Each handover moves the token on a single clock edge. A first-load input chooses the slice that owns both tokens after reset.

A mode input selects cascade or stand-alone use. In stand-alone use the tokens stay put, and the shared output pin carries half-full instead of write expansion-out. A separate merge module combines the active-low flags of all slices into whole-array flags. Both the write and read sides of a slice run on one clock.

Top module: `cascade_slice_ctrl`

## Requirements
- R1: During and after reset, a slice with `first_ni` low holds both tokens and a slice with `first_ni` high holds neither. Pointers and count reset to zero, and `empty_no` is low.
- R2: A write is accepted (`wr_accept_o` high) only when `wr_en_i` is high, the slice holds the write token, and the slice is not full. `wr_addr_o` then steps by one per accepted write, wrapping from DEPTH-1 to 0. With the count at DEPTH and no read, the count stays at DEPTH.
- R3: In cascade mode (`cascade_i`=1), `xo_hf_o` is high for exactly the cycle in which a write is accepted at address DEPTH-1, and the write token is released on that clock edge.
- R4: A slice that sees `wr_xi_i` high at a rising clock edge holds the write token after that edge. Its writes resume at its current write address.
- R5: In cascade mode, `rd_xo_o` is high for exactly the cycle in which a read is accepted at address DEPTH-1. The read token leaves on that edge, and `rd_xi_i` high at an edge gives the receiving slice the read token.
- R6: In stand-alone mode (`cascade_i`=0), `xo_hf_o` is an active-low half-full flag, low while the count exceeds DEPTH/2. The tokens never leave the slice in this mode.
- R7: `q_drive_o` is high only when `oe_i` is high and the slice holds the read token, so at most one slice in a ring drives the bus.
- R8: The per-slice active-low flags are defined as follows. `empty_no` is low at count 0. `full_no` is low at count DEPTH. `aempty_no` is low while count ≤ AE_OFS. `afull_no` is low while count ≥ DEPTH-AF_OFS.
- R9: The merged flags from `cascade_flag_merge` are the bitwise OR of the slices' active-low flags. A merged flag is therefore low only when that flag is low in every slice.
- R10: In a ring, words come out across the slices in the order they were written, and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slice clock, used for both the write and read sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| first_ni | input | 1 | Low marks the first slice, which owns both tokens after reset |
| cascade_i | input | 1 | 1 = cascade ring, 0 = stand-alone |
| oe_i | input | 1 | Output enable request for the shared data bus |
| wr_en_i | input | 1 | Shared write enable |
| rd_en_i | input | 1 | Shared read enable |
| wr_xi_i | input | 1 | Write expansion-in from the previous slice |
| rd_xi_i | input | 1 | Read expansion-in from the previous slice |
| wr_accept_o | output | 1 | Write strobe to this slice's storage |
| wr_addr_o | output | AW | Storage write address |
| rd_accept_o | output | 1 | Read strobe to this slice's storage |
| rd_addr_o | output | AW | Storage read address |
| wr_tok_o | output | 1 | Slice holds the write token |
| rd_tok_o | output | 1 | Slice holds the read token |
| xo_hf_o | output | 1 | Write expansion-out pulse (cascade) or active-low half-full (stand-alone) |
| rd_xo_o | output | 1 | Read expansion-out pulse |
| q_drive_o | output | 1 | Enable for this slice's output drivers |
| empty_no | output | 1 | Active-low empty |
| full_no | output | 1 | Active-low full |
| aempty_no | output | 1 | Active-low almost-empty |
| afull_no | output | 1 | Active-low almost-full |

## Verification
The bench builds a ring of three slices around a data model, plus one stand-alone slice.

A token held by two slices, or by none, shows up within one cycle. Either two write strobes appear on the shared bus, or a pending write goes unaccepted. A wrong read-token state shows up as more than one active `q_drive_o`, or as a word that the scoreboard receives out of order at the next read.

An expansion pulse that is missing or one cycle late is caught at the cycle of the last-location access. A stuck count appears in the flags right after the write or read that should have changed it.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  typedef struct packed {
    logic empty_n;
    logic aempty_n;
    logic afull_n;
    logic full_n;
  } slice_flags_t;
endpackage

// File: rtl/token_stage.sv
module token_stage #(
  parameter int unsigned AW   = 4,
  parameter int unsigned LAST = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          own_i,
  input  logic          pass_en_i,
  input  logic          req_i,
  input  logic          block_i,
  input  logic          xi_i,
  output logic          tok_o,
  output logic          fire_o,
  output logic [AW-1:0] ptr_o,
  output logic          xo_o
);
  localparam logic [AW-1:0] LastP = AW'(LAST);

  logic          tok_q;
  logic [AW-1:0] ptr_q;
  logic          at_last;

  assign at_last = (ptr_q == LastP);
  assign fire_o  = req_i & tok_q & ~block_i;
  // combinational pulse: receiver samples it on the same edge the token leaves
  assign xo_o    = fire_o & at_last & pass_en_i;
  assign tok_o   = tok_q;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q <= own_i;
      ptr_q <= '0;
    end else begin
      if (fire_o) ptr_q <= at_last ? '0 : ptr_q + 1'b1;
      if (xo_o)      tok_q <= 1'b0;
      else if (xi_i) tok_q <= 1'b1;
    end
  end

  // R3 R5
  tok_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xo_o && !xi_i |=> !tok_o);
  // R3 R5
  xo_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xo_o |=> !xo_o);
  // R4
  tok_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xi_i && !xo_o |=> tok_o);
endmodule

// File: rtl/slice_level.sv
module slice_level
  import cascade_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AE_OFS = 3,
  parameter int unsigned AF_OFS = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         rd_i,
  output slice_flags_t flags_o,
  output logic         hf_no
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FullC = CW'(DEPTH);
  localparam logic [CW-1:0] AeC   = CW'(AE_OFS);
  localparam logic [CW-1:0] AfC   = CW'(DEPTH - AF_OFS);
  localparam logic [CW-1:0] HalfC = CW'(DEPTH / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign flags_o.empty_n  = (cnt_q != '0);
  assign flags_o.full_n   = (cnt_q != FullC);
  assign flags_o.aempty_n = (cnt_q > AeC);
  assign flags_o.afull_n  = (cnt_q < AfC);
  assign hf_no            = !(cnt_q > HalfC);

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FullC);
  // R2
  hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FullC) && !rd_i |=> (cnt_q == FullC));
endmodule

// File: rtl/cascade_flag_merge.sv
module cascade_flag_merge
  import cascade_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  slice_flags_t [N-1:0] slice_i,
  output slice_flags_t         merged_o
);
  always_comb begin
    merged_o = '0;
    for (int i = 0; i < N; i++) merged_o = slice_flags_t'(merged_o | slice_i[i]);
  end
endmodule

// File: rtl/cascade_slice_ctrl.sv
module cascade_slice_ctrl
  import cascade_pkg::*;
#(
  parameter  int unsigned DEPTH  = 16,
  parameter  int unsigned AE_OFS = 3,
  parameter  int unsigned AF_OFS = 3,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_ni,
  input  logic          cascade_i,
  input  logic          oe_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          wr_xi_i,
  input  logic          rd_xi_i,
  output logic          wr_accept_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_accept_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_tok_o,
  output logic          rd_tok_o,
  output logic          xo_hf_o,
  output logic          rd_xo_o,
  output logic          q_drive_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          aempty_no,
  output logic          afull_no
);
  slice_flags_t flg;
  logic         wr_xo, hf_n;

  token_stage #(.AW(AW), .LAST(DEPTH - 1)) u_wr_tok (
    .clk_i, .rst_ni,
    .own_i    (~first_ni),
    .pass_en_i(cascade_i),
    .req_i    (wr_en_i),
    .block_i  (~flg.full_n),
    .xi_i     (wr_xi_i),
    .tok_o    (wr_tok_o),
    .fire_o   (wr_accept_o),
    .ptr_o    (wr_addr_o),
    .xo_o     (wr_xo)
  );

  token_stage #(.AW(AW), .LAST(DEPTH - 1)) u_rd_tok (
    .clk_i, .rst_ni,
    .own_i    (~first_ni),
    .pass_en_i(cascade_i),
    .req_i    (rd_en_i),
    .block_i  (~flg.empty_n),
    .xi_i     (rd_xi_i),
    .tok_o    (rd_tok_o),
    .fire_o   (rd_accept_o),
    .ptr_o    (rd_addr_o),
    .xo_o     (rd_xo_o)
  );

  slice_level #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_level (
    .clk_i, .rst_ni,
    .wr_i   (wr_accept_o),
    .rd_i   (rd_accept_o),
    .flags_o(flg),
    .hf_no  (hf_n)
  );

  // shared pin: expansion pulse in a ring, half-full alone
  assign xo_hf_o   = cascade_i ? wr_xo : hf_n;
  assign q_drive_o = oe_i & rd_tok_o;
  assign empty_no  = flg.empty_n;
  assign full_no   = flg.full_n;
  assign aempty_no = flg.aempty_n;
  assign afull_no  = flg.afull_n;

  // R6
  sa_keep_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_i && wr_tok_o && !wr_xi_i |=> wr_tok_o);
  // R6
  sa_keep_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_i && rd_tok_o && !rd_xi_i |=> rd_tok_o);
endmodule

// File: tb/tb_cascade_slice_ctrl.sv
`timescale 1ns/1ps
module tb_cascade_slice_ctrl;
  import cascade_pkg::*;
  localparam int D = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, oe = 0, sa_wr = 0, sa_rd = 0;
  logic [15:0] din = '0;
  int n_chk = 0, n_fail = 0;

  logic [2:0] wacc, racc, wtok, rtok, xoh, rxo, qd, emp, ful, aem, afu;
  logic [1:0] wadr [3];
  logic [1:0] radr [3];
  logic [15:0] mem [3][D];
  logic [15:0] exp_q [$];
  slice_flags_t [2:0] fl;
  slice_flags_t mrg;

  logic sa_wacc, sa_racc, sa_wtok, sa_rtok, sa_pin, sa_rxo, sa_qd;
  logic sa_emp, sa_ful, sa_aem, sa_afu;
  logic [1:0] sa_wadr, sa_radr;

  always #10 clk = ~clk;

  cascade_slice_ctrl #(.DEPTH(D), .AE_OFS(1), .AF_OFS(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .first_ni(1'b0), .cascade_i(1'b1), .oe_i(oe),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_xi_i(xoh[2]), .rd_xi_i(rxo[2]),
    .wr_accept_o(wacc[0]), .wr_addr_o(wadr[0]), .rd_accept_o(racc[0]), .rd_addr_o(radr[0]),
    .wr_tok_o(wtok[0]), .rd_tok_o(rtok[0]), .xo_hf_o(xoh[0]), .rd_xo_o(rxo[0]),
    .q_drive_o(qd[0]), .empty_no(emp[0]), .full_no(ful[0]), .aempty_no(aem[0]), .afull_no(afu[0]));
  cascade_slice_ctrl #(.DEPTH(D), .AE_OFS(1), .AF_OFS(1)) u_s1 (
    .clk_i(clk), .rst_ni(rst_n), .first_ni(1'b1), .cascade_i(1'b1), .oe_i(oe),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_xi_i(xoh[0]), .rd_xi_i(rxo[0]),
    .wr_accept_o(wacc[1]), .wr_addr_o(wadr[1]), .rd_accept_o(racc[1]), .rd_addr_o(radr[1]),
    .wr_tok_o(wtok[1]), .rd_tok_o(rtok[1]), .xo_hf_o(xoh[1]), .rd_xo_o(rxo[1]),
    .q_drive_o(qd[1]), .empty_no(emp[1]), .full_no(ful[1]), .aempty_no(aem[1]), .afull_no(afu[1]));
  cascade_slice_ctrl #(.DEPTH(D), .AE_OFS(1), .AF_OFS(1)) u_s2 (
    .clk_i(clk), .rst_ni(rst_n), .first_ni(1'b1), .cascade_i(1'b1), .oe_i(oe),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_xi_i(xoh[1]), .rd_xi_i(rxo[1]),
    .wr_accept_o(wacc[2]), .wr_addr_o(wadr[2]), .rd_accept_o(racc[2]), .rd_addr_o(radr[2]),
    .wr_tok_o(wtok[2]), .rd_tok_o(rtok[2]), .xo_hf_o(xoh[2]), .rd_xo_o(rxo[2]),
    .q_drive_o(qd[2]), .empty_no(emp[2]), .full_no(ful[2]), .aempty_no(aem[2]), .afull_no(afu[2]));
  cascade_slice_ctrl #(.DEPTH(D), .AE_OFS(1), .AF_OFS(1)) u_sa (
    .clk_i(clk), .rst_ni(rst_n), .first_ni(1'b0), .cascade_i(1'b0), .oe_i(1'b1),
    .wr_en_i(sa_wr), .rd_en_i(sa_rd), .wr_xi_i(1'b0), .rd_xi_i(1'b0),
    .wr_accept_o(sa_wacc), .wr_addr_o(sa_wadr), .rd_accept_o(sa_racc), .rd_addr_o(sa_radr),
    .wr_tok_o(sa_wtok), .rd_tok_o(sa_rtok), .xo_hf_o(sa_pin), .rd_xo_o(sa_rxo),
    .q_drive_o(sa_qd), .empty_no(sa_emp), .full_no(sa_ful), .aempty_no(sa_aem), .afull_no(sa_afu));

  for (genvar k = 0; k < 3; k++) begin : g_fl
    assign fl[k] = '{empty_n: emp[k], aempty_n: aem[k], afull_n: afu[k], full_n: ful[k]};
  end
  cascade_flag_merge #(.N(3)) u_merge (.slice_i(fl), .merged_o(mrg));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: reads before writes in the same cycle
  always @(negedge clk) if (rst_n) begin
    for (int k = 0; k < 3; k++) begin
      check("R3 xo", 32'(xoh[k]), 32'(wacc[k] && wadr[k] == 2'd3));
      check("R5 rxo", 32'(rxo[k]), 32'(racc[k] && radr[k] == 2'd3));
      if (racc[k]) begin
        if (exp_q.size() == 0) check("R10 underflow", 32'(mem[k][radr[k]]), 32'hffff_ffff);
        else check("R10 data", 32'(mem[k][radr[k]]), 32'(exp_q.pop_front()));
      end
    end
    check("R7 one driver", 32'($countones(qd)), 32'(oe ? 1 : 0));
    check("R2 one writer", 32'($countones(wacc) <= 1), 32'd1);
    for (int k = 0; k < 3; k++) if (wacc[k]) mem[k][wadr[k]] = din;
  end

  task automatic do_writes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; wr_en = 1; din = 16'(base + i); exp_q.push_back(16'(base + i));
    end
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; rd_en = 1; end
    @(posedge clk); #2; rd_en = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    settle();
    // R1
    check("R1 wtok", 32'(wtok), 32'b001);
    check("R1 rtok", 32'(rtok), 32'b001);
    check("R1 empty", 32'(mrg.empty_n), 32'd0);
    check("R1 sa tok", 32'({sa_wtok, sa_rtok}), 32'b11);
    check("R1 waddr", 32'(wadr[0]), 32'd0);

    oe = 1;
    do_writes(10, 16'h100);
    settle();
    check("R4 wtok moved", 32'(wtok), 32'b100);
    check("R4 addr resume", 32'(wadr[2]), 32'd2);
    check("R8 slice full", 32'(ful[0]), 32'd0);
    check("R9 merged full", 32'(mrg.full_n), 32'd1);
    check("R9 merged empty", 32'(mrg.empty_n), 32'd1);

    do_reads(10);
    settle();
    check("R5 rtok moved", 32'(rtok), 32'b100);
    check("R9 all empty", 32'(mrg.empty_n), 32'd0);

    do_writes(12, 16'h200);
    settle();
    check("R9 all full", 32'(mrg.full_n), 32'd0);
    check("R2 wtok", 32'(wtok), 32'b100);
    @(posedge clk); #2; wr_en = 1; din = 16'hdead;
    settle();
    check("R2 blocked", 32'(wacc), 32'd0);
    @(posedge clk); #2; wr_en = 0;
    do_reads(12);
    settle();
    check("R10 drained", 32'(exp_q.size()), 32'd0);
    check("R9 empty again", 32'(mrg.empty_n), 32'd0);
    oe = 0;
    settle();
    check("R7 oe off", 32'(qd), 32'd0);

    // stand-alone slice
    check("R6 hf idle", 32'(sa_pin), 32'd1);
    check("R8 sa aempty", 32'(sa_aem), 32'd0);
    for (int i = 0; i < 3; i++) begin @(posedge clk); #2; sa_wr = 1; end
    @(posedge clk); #2; sa_wr = 0;
    settle();
    check("R6 hf low", 32'(sa_pin), 32'd0);
    check("R8 sa aempty3", 32'(sa_aem), 32'd1);
    check("R8 sa afull3", 32'(sa_afu), 32'd0);
    @(posedge clk); #2; sa_wr = 1;
    settle();
    check("R6 last addr", 32'({sa_wacc, sa_wadr}), 32'b111);
    check("R6 no pulse", 32'(sa_pin), 32'd0);
    @(posedge clk); #2; sa_wr = 0;
    settle();
    check("R6 tok kept", 32'(sa_wtok), 32'd1);
    check("R8 sa full", 32'(sa_ful), 32'd0);
    for (int i = 0; i < 3; i++) begin @(posedge clk); #2; sa_rd = 1; end
    @(posedge clk); #2; sa_rd = 0;
    settle();
    check("R8 sa aempty1", 32'(sa_aem), 32'd0);
    check("R6 hf high", 32'(sa_pin), 32'd1);
    check("R6 rtok kept", 32'(sa_rtok), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule